// File: doc/BRIEF.md
# Banked Program Counter Branch Unit

This block holds the 12-bit program counter of a small controller and produces the ROM fetch address for every instruction cycle. The counter has three fields. The top bit selects one of two banks. The next 5 bits select a page within the bank. The low 6 bits select a word within the page. The block also holds the status flip-flop, which makes some of the jumps conditional.

Each cycle the surrounding decoder presents the decoded instruction at the current fetch address, along with its operand and the current datapath values: the 4-bit accumulator, the 4-bit B register, the carry flag and one I/O register bit. At the clock edge the block computes the next address. With no jump, the word address steps forward and wraps inside the page. The in-page branch loads the word field. The page/bank preload reaches the counter one cycle late, so pairing it with an in-page branch right after it gives a long jump to any location. The table branch builds a complete target from the datapath values.

A test instruction code writes the status flag from outside, which is how the ALU's comparisons and flag results reach it.

Top module: `pc_branch_unit`

## Requirements
- R1: A synchronous active-low reset clears bank, page and word address to 0, sets status to 1 and discards any pending preload.
- R2: On opcode 0 (sequential) and on any unused code (5..7), the word address increments by one and wraps from 63 to 0 without changing the page or the bank. Status is unchanged.
- R3: Opcode 1 (in-page branch) with status 1 loads operand bits [5:0] into the word address. Bank, page and status are unchanged.
- R4: Opcode 1 with status 0 does not branch. The word address increments and status becomes 1.
- R5: Opcode 2 (preload) with status 1 does not change bank or page at its own clock edge. At the following edge the page becomes operand bits [4:0] and the bank becomes the inverse of the I/O bit. The word address increments as in R2.
- R6: Opcode 2 with status 0 is skipped. Status stays 0 and no bank or page change follows.
- R7: A preload followed by an in-page branch, both with status 1, lands on the bank, page and word they name. The same pair with status 0 lands on neither, and status ends at 1.
- R8: Opcode 3 (table branch) with operand bits [2:0] = p sets the word address to {B[1:0], A[3:0]} and the page to {p[1:0], carry, B[3:2]}.
- R9: On a table branch the new bank is the current bank ORed with p[2]. From bank 1 it stays in bank 1.
- R10: A table branch executes when status is 0 or 1 and leaves status unchanged.
- R11: Opcode 4 (test) loads the status from the test input and increments the word address.
- R12: A pending preload sets bank and page at its edge, whatever instruction runs in that cycle, including a table branch. The word field still follows that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Decoded instruction code (0 seq, 1 in-page branch, 2 preload, 3 table branch, 4 test) |
| operand | input | 6 | Immediate operand of the instruction |
| acc | input | 4 | Accumulator value |
| breg | input | 4 | B register value |
| carry | input | 1 | Carry flag |
| io_bit | input | 1 | I/O register bit that selects the preload bank (inverted) |
| test_val | input | 1 | Status value written by the test code |
| rom_addr | output | 12 | Current fetch address {bank, page, word} |
| status | output | 1 | Status flip-flop |

## Verification
The bench uses the package's default field widths: a 6-bit word, a 5-bit page, one bank bit and 4-bit datapath values. At these widths a directed run of 64 steps reaches the in-page wrap. Random table branches reach every page and both banks within a few hundred cycles. Random opcode sequences produce back-to-back preloads, preloads followed by table branches, and skipped pairs while status is 0. This covers the ordering between a pending preload and the instruction that follows it.

// File: rtl/pcb_pkg.sv
// Package: shared field widths, instruction codes and the program counter
// layout for the banked branch unit. Assumes a single bank bit.
package pcb_pkg;
    localparam int WORD_W = 6;                       // in-page address width
    localparam int PAGE_W = 5;                       // page field width
    localparam int DATA_W = 4;                       // accumulator / B width
    localparam int PC_W   = 1 + PAGE_W + WORD_W;     // full fetch address
    localparam int OP_W   = 3;
    localparam int TP_W   = 3;                       // table operand width

    typedef enum logic [OP_W-1:0] {
        OP_SEQ  = 3'd0,
        OP_BR   = 3'd1,
        OP_LPRE = 3'd2,
        OP_TBL  = 3'd3,
        OP_TEST = 3'd4
    } op_e;

    typedef struct packed {
        logic              bank;
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] word;
    } pc_t;
endpackage

// File: rtl/pcb_status.sv
// Status flip-flop. A skipped in-page branch sets it. The test code loads it.
// Every other code holds it. Assumes op is one decoded code per cycle.
module pcb_status
    import pcb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OP_W-1:0] op,
    input  logic           test_val,
    output logic           status
);
    logic status_d;

    // Next status value from the current instruction.
    always_comb begin
        status_d = status;
        if (op == OP_BR && !status)
            status_d = 1'b1;
        else if (op == OP_TEST)
            status_d = test_val;
    end

    // Status register, set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= 1'b1;
        else        status <= status_d;
    end

    p_br_skip_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BR && !status) |=> status);
    p_lpre_skip_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LPRE && !status) |=> !status);
    p_tbl_keeps_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TBL) |=> $stable(status));
endmodule

// File: rtl/pcb_preload.sv
// One-deep pending bank/page register. A taken preload fills it. It then
// stays valid for exactly one cycle and is consumed at the next edge.
// Assumes the load strobe is already qualified by status.
module pcb_preload
    import pcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bank_in,
    input  logic [PAGE_W-1:0] page_in,
    output logic              pend_valid,
    output logic              pend_bank,
    output logic [PAGE_W-1:0] pend_page
);
    // Valid bit: set by a load, cleared once the entry has been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_valid <= 1'b0;
        else        pend_valid <= load;
    end

    // Payload register, captured on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bank <= 1'b0;
            pend_page <= '0;
        end else if (load) begin
            pend_bank <= bank_in;
            pend_page <= page_in;
        end
    end

    p_pend_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pend_valid && pend_page == $past(page_in) && pend_bank == $past(bank_in)));
endmodule

// File: rtl/pcb_next.sv
// Combinational next-address logic. It picks the word field from the current
// instruction, then lets a pending preload override bank and page.
// Assumes status is the registered flag for the current cycle.
module pcb_next
    import pcb_pkg::*;
(
    input  pc_t               pc_q,
    input  logic [OP_W-1:0]   op,
    input  logic              status,
    input  logic [WORD_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] breg,
    input  logic              carry,
    input  logic              pend_valid,
    input  logic              pend_bank,
    input  logic [PAGE_W-1:0] pend_page,
    output pc_t               pc_d
);
    localparam int BLO_W = WORD_W - DATA_W;      // B bits used in the word field
    localparam int BHI_W = DATA_W - BLO_W;       // B bits used in the page field

    logic [TP_W-1:0] tp;
    pc_t             by_instr;

    assign tp = operand[TP_W-1:0];

    // Target selected by the instruction alone.
    always_comb begin
        by_instr      = pc_q;
        by_instr.word = pc_q.word + 1'b1;
        unique case (op)
            OP_BR: begin
                if (status) by_instr.word = operand;
            end
            OP_TBL: begin
                by_instr.word = {breg[BLO_W-1:0], acc};
                by_instr.page = {tp[1:0], carry, breg[DATA_W-1:BLO_W]};
                by_instr.bank = pc_q.bank | tp[2];
            end
            default: ;
        endcase
    end

    // A pending preload wins the bank and page fields.
    always_comb begin
        pc_d = by_instr;
        if (pend_valid) begin
            pc_d.bank = pend_bank;
            pc_d.page = pend_page;
        end
    end

    initial begin
        if (BHI_W + 3 != PAGE_W)
            $display("pcb_next: table page mapping needs PAGE_W = %0d", BHI_W + 3);
    end
endmodule

// File: rtl/pc_branch_unit.sv
// Top level: the program counter register plus the status, preload and
// next-address pieces. rom_addr is the address being fetched in this cycle.
// op and its inputs belong to the instruction at that address.
module pc_branch_unit
    import pcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] breg,
    input  logic              carry,
    input  logic              io_bit,
    input  logic              test_val,
    output logic [PC_W-1:0]   rom_addr,
    output logic              status
);
    pc_t               pc_q;
    pc_t               pc_d;
    logic              pre_load;
    logic              pend_valid;
    logic              pend_bank;
    logic [PAGE_W-1:0] pend_page;

    assign pre_load = (op == OP_LPRE) && status;
    assign rom_addr = pc_q;

    pcb_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .test_val (test_val),
        .status   (status)
    );

    pcb_preload u_preload (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pre_load),
        .bank_in    (~io_bit),
        .page_in    (operand[PAGE_W-1:0]),
        .pend_valid (pend_valid),
        .pend_bank  (pend_bank),
        .pend_page  (pend_page)
    );

    pcb_next u_next (
        .pc_q       (pc_q),
        .op         (op),
        .status     (status),
        .operand    (operand),
        .acc        (acc),
        .breg       (breg),
        .carry      (carry),
        .pend_valid (pend_valid),
        .pend_bank  (pend_bank),
        .pend_page  (pend_page),
        .pc_d       (pc_d)
    );

    // Program counter register, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SEQ && !pend_valid) |=>
            (pc_q.word == $past(pc_q.word) + 1'b1 && $stable(pc_q.page) && $stable(pc_q.bank)));
    p_br_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BR && status && !pend_valid) |=>
            (pc_q.word == $past(operand) && $stable(pc_q.page) && $stable(pc_q.bank)));
    p_pre_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LPRE && !pend_valid) |=> ($stable(pc_q.page) && $stable(pc_q.bank)));
    p_tbl_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TBL && pc_q.bank && !pend_valid) |=> pc_q.bank);
    p_pend_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> (pc_q.page == $past(pend_page) && pc_q.bank == $past(pend_bank)));
endmodule

// File: tb/pc_branch_unit_test.sv
module pc_branch_unit_test;
    import pcb_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [OP_W-1:0]   op;
    logic [WORD_W-1:0] operand;
    logic [DATA_W-1:0] acc, breg;
    logic              carry, io_bit, test_val;
    logic [PC_W-1:0]   rom_addr;
    logic              status;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    logic              m_bank, m_st, m_pv, m_pb;
    logic [PAGE_W-1:0] m_page, m_pp;
    logic [WORD_W-1:0] m_word;

    always #2 clk = ~clk;

    pc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .op(op), .operand(operand), .acc(acc),
        .breg(breg), .carry(carry), .io_bit(io_bit), .test_val(test_val),
        .rom_addr(rom_addr), .status(status)
    );

    function automatic logic [PC_W-1:0] model_addr();
        return {m_bank, m_page, m_word};
    endfunction

    task automatic check(string req, logic [PC_W-1:0] ga, logic [PC_W-1:0] ea,
                         logic gs, logic es);
        n_chk++;
        if (ga !== ea || gs !== es) begin
            n_fail++;
            $display("FAIL %s: addr=%h status=%b, expected addr=%h status=%b",
                     req, ga, gs, ea, es);
        end
    endtask

    // Next model state from the requirements.
    task automatic model_step(logic [OP_W-1:0] o, logic [WORD_W-1:0] d,
                              logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                              logic c, logic io, logic tv);
        logic              nb, ns, npv, npb;
        logic [PAGE_W-1:0] np, npp;
        logic [WORD_W-1:0] nw;
        nb = m_bank; np = m_page; nw = m_word + 1'b1; ns = m_st;
        npv = 1'b0; npb = m_pb; npp = m_pp;
        case (o)
            3'd1: if (m_st) nw = d; else ns = 1'b1;
            3'd2: if (m_st) begin npv = 1'b1; npb = ~io; npp = d[PAGE_W-1:0]; end
            3'd3: begin
                nw = {b[1:0], a};
                np = {d[1:0], c, b[3:2]};
                nb = m_bank | d[2];
            end
            3'd4: ns = tv;
            default: ;
        endcase
        if (m_pv) begin nb = m_pb; np = m_pp; end
        m_bank = nb; m_page = np; m_word = nw; m_st = ns;
        m_pv = npv; m_pb = npb; m_pp = npp;
    endtask

    // Drive one instruction at the falling edge, then compare after the rising edge.
    task automatic step(logic [OP_W-1:0] o, logic [WORD_W-1:0] d,
                        logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                        logic c, logic io, logic tv, string req);
        op = o; operand = d; acc = a; breg = b; carry = c; io_bit = io; test_val = tv;
        model_step(o, d, a, b, c, io, tv);
        @(posedge clk);
        @(negedge clk);
        check(req, rom_addr, model_addr(), status, m_st);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op = 3'd0; operand = '0; acc = '0; breg = '0;
        carry = 1'b0; io_bit = 1'b0; test_val = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_bank = 0; m_page = '0; m_word = '0; m_st = 1'b1;
        m_pv = 1'b0; m_pb = 1'b0; m_pp = '0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // R1: reset state.
        do_reset();
        check("R1", rom_addr, 12'h000, status, 1'b1);

        // R2: 64 sequential steps wrap the word inside page 0.
        for (int i = 0; i < 64; i++) step(3'd0, '0, '0, '0, 0, 0, 0, "R2");
        check("R2", rom_addr, 12'h000, status, 1'b1);
        step(3'd6, '0, '0, '0, 0, 0, 0, "R2");
        check("R2", rom_addr, 12'h001, status, 1'b1);

        // R3: taken in-page branch.
        step(3'd1, 6'h2C, '0, '0, 0, 0, 0, "R3");
        check("R3", rom_addr, 12'h02C, status, 1'b1);

        // R11 and R4: clear status, then a skipped branch sets it again.
        step(3'd4, '0, '0, '0, 0, 0, 0, "R11");
        check("R11", rom_addr, 12'h02D, status, 1'b0);
        step(3'd1, 6'h05, '0, '0, 0, 0, 0, "R4");
        check("R4", rom_addr, 12'h02E, status, 1'b1);

        // R5 and R7: long jump to bank 1, page 0x15, word 0x2A.
        do_reset();
        step(3'd2, 6'h15, '0, '0, 0, 0, 0, "R5");
        check("R5", rom_addr, 12'h001, status, 1'b1);
        step(3'd1, 6'h2A, '0, '0, 0, 0, 0, "R7");
        check("R7", rom_addr, 12'hD6A, status, 1'b1);

        // R6 and R7: the skipped pair leaves bank/page alone and ends with status 1.
        do_reset();
        step(3'd4, '0, '0, '0, 0, 0, 0, "R11");
        step(3'd2, 6'h1F, '0, '0, 0, 0, 0, "R6");
        check("R6", rom_addr, 12'h002, status, 1'b0);
        step(3'd1, 6'h30, '0, '0, 0, 0, 0, "R7");
        check("R7", rom_addr, 12'h003, status, 1'b1);
        step(3'd0, '0, '0, '0, 0, 0, 0, "R6");
        check("R6", rom_addr, 12'h004, status, 1'b1);

        // R8, R9, R10: table branches.
        do_reset();
        step(3'd3, 6'b000011, 4'hA, 4'b1101, 1, 0, 0, "R8");
        check("R8", rom_addr, 12'h7DA, status, 1'b1);
        step(3'd3, 6'b000100, 4'h0, 4'h0, 0, 0, 0, "R9");
        check("R9", rom_addr, 12'h800, status, 1'b1);
        step(3'd4, '0, '0, '0, 0, 0, 0, "R11");
        step(3'd3, 6'b000000, 4'h5, 4'h0, 0, 0, 0, "R10");
        check("R10", rom_addr, 12'h805, status, 1'b0);

        // R12: a pending preload wins over the table branch's bank and page.
        do_reset();
        step(3'd2, 6'h03, '0, '0, 0, 1, 0, "R12");
        step(3'd3, 6'b000100, 4'h0, 4'h0, 0, 0, 0, "R12");
        check("R12", rom_addr, 12'h0C0, status, 1'b1);

        // Random mix checked against the model each cycle.
        do_reset();
        for (int i = 0; i < 600; i++) begin
            logic [OP_W-1:0] o;
            string tag;
            o = 3'($urandom % 6);
            case (o)
                3'd1: tag = "R3";
                3'd2: tag = "R5";
                3'd3: tag = "R8";
                3'd4: tag = "R11";
                default: tag = "R2";
            endcase
            step(o, 6'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), tag);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule